// File: doc/BRIEF.md
# Add-Subtract and Set-Less-Than Unit

This is a combinational datapath slice. It takes two operand words and a 4-bit operation code. It returns a result word and three flags: carry-out, signed overflow and zero. The two upper code bits pick an operation class. Class `01` is arithmetic and class `10` is comparison. The two lower code bits pick the operation inside that class.

One adder serves both the signed and the unsigned variants of addition and subtraction. To subtract, it inverts the second operand and forces the carry-in high. The two less-than operations have no comparator of their own. They always run that same subtraction, then derive the answer from the operand signs, the sign of the difference and the adder carry. The 1-bit answer goes into the least significant bit of an otherwise zero word.

Code classes `00` and `11` are outside this unit's scope. A surrounding datapath uses them for other operation families, and this unit drives a zero result for them.

Top module: `addsub_slt_unit`

## Requirements
- R1: With code bits [3:2] = `01` and bits [1:0] = `00` (ADD) or `01` (ADDU), the result is A + B modulo 2^WIDTH, and carry_out is bit WIDTH of the unsigned sum.
- R2: With code bits [3:2] = `01` and bits [1:0] = `10` (SUB) or `11` (SUBU), the result is A - B modulo 2^WIDTH. carry_out is the carry of A + ~B + 1, so it is 1 exactly when A >= B unsigned.
- R3: overflow is 1 only for ADD (`0100`) and SUB (`0110`), and only when the two words entering the adder have equal signs and the sum's sign differs from them. It is 0 for ADDU, SUBU and every other code.
- R4: zero is 1 exactly when all bits of the result word are 0.
- R5: Code `1010` (signed less-than) returns 1 in bit 0 when A < B as two's complement numbers, including when A - B overflows, and 0 otherwise. All higher bits are 0.
- R6: Code `1011` (unsigned less-than) returns 1 in bit 0 exactly when A < B unsigned, which is when the subtraction carry is 0. All higher bits are 0.
- R7: Codes `1000` and `1001` return an all-zero result.
- R8: In the comparison class, carry_out is the carry of the internal A + ~B + 1, and overflow is 0.
- R9: Codes with bits [3:2] = `00` or `11` give result 0, carry_out 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand (A) |
| opb | input | WIDTH | Second operand (B) |
| op_code | input | 4 | Bits [3:2] select the class, bits [1:0] select the operation |
| result | output | WIDTH | Sum, difference or less-than word |
| carry_out | output | 1 | Adder carry-out |
| overflow | output | 1 | Signed overflow of ADD or SUB |
| zero | output | 1 | Result word is all zeros |

## Verification
The hardest case is a signed less-than whose internal subtraction overflows. In that case the sign of the difference gives the wrong answer, and only the operand-sign path gives the right one. The stimulus reaches it on purpose with directed pairs such as the most negative value against 1 and the most positive value against -1. A pseudo-random sweep then crosses mixed-sign pairs with every operation code. Signed-overflow boundaries and the all-zero difference of equal operands are also driven on purpose, because random data rarely lands on them.

// File: rtl/addsub_slt_unit.sv
module addsub_slt_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;
  localparam logic [1:0] CLS_ARITH = 2'b01;
  localparam logic [1:0] CLS_CMP   = 2'b10;

  logic [1:0] cls, sel;
  logic is_arith, is_cmp, do_sub;
  logic [WIDTH-1:0] b_in;
  logic [WIDTH:0]   sum_w;
  logic a_s, b_s, r_s, cy;
  logic slt_bit, sltu_bit, lt_bit, ovf_raw;

  assign cls      = op_code[3:2];
  assign sel      = op_code[1:0];
  assign is_arith = (cls == CLS_ARITH);
  assign is_cmp   = (cls == CLS_CMP);
  assign do_sub   = is_cmp | sel[1];

  assign b_in  = do_sub ? ~opb : opb;
  assign sum_w = {1'b0, opa} + {1'b0, b_in} + {{WIDTH{1'b0}}, do_sub};

  assign a_s = opa[MSB];
  assign b_s = opb[MSB];
  assign r_s = sum_w[MSB];
  assign cy  = sum_w[WIDTH];

  assign slt_bit  = (a_s == b_s) ? r_s : a_s;
  assign sltu_bit = ~cy;
  assign lt_bit   = (sel == 2'b10) ? slt_bit :
                    (sel == 2'b11) ? sltu_bit : 1'b0;

  assign ovf_raw = (opa[MSB] == b_in[MSB]) && (r_s != opa[MSB]);

  assign result    = is_arith ? sum_w[MSB:0] :
                     is_cmp   ? {{(WIDTH-1){1'b0}}, lt_bit} : '0;
  assign carry_out = (is_arith | is_cmp) & cy;
  assign overflow  = is_arith & ~sel[0] & ovf_raw;
  assign zero      = ~|result;

  always_comb begin
    if (is_arith && !sel[1])
      AST_ADD_SUM: assert (result == opa + opb) else $error("add sum");  // R1
    if (is_arith && sel[1])
      AST_SUB_DIFF: assert (result == opa - opb) else $error("sub diff");  // R2
    if (!is_arith || sel[0])
      AST_NO_OVERFLOW: assert (!overflow) else $error("overflow");  // R3
    if (is_cmp && sel == 2'b10)
      AST_SLT_VALUE: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opa) < $signed(opb))}) else $error("slt");  // R5
    if (is_cmp && sel == 2'b11)
      AST_SLTU_VALUE: assert (result == {{(WIDTH-1){1'b0}}, (opa < opb)}) else $error("sltu");  // R6
    if (is_cmp)
      AST_CMP_UPPER: assert (result[MSB:1] == '0) else $error("cmp upper");  // R7
    if (!is_arith && !is_cmp)
      AST_IDLE_CLASS: assert (result == '0 && !carry_out) else $error("idle");  // R9
  end
endmodule

// File: tb/sim_addsub_slt_unit.sv
module sim_addsub_slt_unit;
  localparam int W = 32;
  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic [W-1:0] opa, opb, result;
  logic [3:0]   op_code;
  logic carry_out, overflow, zero;

  addsub_slt_unit #(.WIDTH(W)) u0 (
    .opa(opa), .opb(opb), .op_code(op_code),
    .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero));

  typedef struct {
    logic [W-1:0] res;
    logic cy, ov, zf;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] op, string req);
    exp_t e;
    logic [W:0]   subw, addw;
    logic [W+1:0] sa, ss;
    addw = {1'b0, a} + {1'b0, b};
    subw = {1'b0, a} + {1'b0, ~b} + 1;
    sa = {{2{a[W-1]}}, a} + {{2{b[W-1]}}, b};
    ss = {{2{a[W-1]}}, a} - {{2{b[W-1]}}, b};
    e.res = '0; e.cy = 0; e.ov = 0; e.req = req;
    case (op)
      4'b0100: begin e.res = addw[W-1:0]; e.cy = addw[W]; e.ov = sa[W] != sa[W-1]; end
      4'b0101: begin e.res = addw[W-1:0]; e.cy = addw[W]; end
      4'b0110: begin e.res = a - b; e.cy = (a >= b); e.ov = ss[W] != ss[W-1]; end
      4'b0111: begin e.res = a - b; e.cy = (a >= b); end
      4'b1000, 4'b1001: e.cy = subw[W];
      4'b1010: begin e.res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))}; e.cy = subw[W]; end
      4'b1011: begin e.res = {{(W-1){1'b0}}, (a < b)}; e.cy = subw[W]; end
      default: ;
    endcase
    e.zf = (e.res == '0);
    return e;
  endfunction

  task automatic send(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] op, string req);
    @(posedge clk);
    opa <= a; opb <= b; op_code <= op;
    q.push_back(model(a, b, op, req));
  endtask

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "result", result, e.res);
      chk(e.req, "carry", {31'b0, carry_out}, {31'b0, e.cy});
      chk(e.req, "overflow", {31'b0, overflow}, {31'b0, e.ov});
      chk("R4", "zero", {31'b0, zero}, {31'b0, e.zf});
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb;
    opa = '0; opb = '0; op_code = '0;
    repeat (3) @(posedge clk);
    rst = 0;
    send(32'h1234, 32'h5678, 4'b0000, "R9");
    send(32'hFFFF_FFFF, 32'h1, 4'b1100, "R9");
    send(32'd5, 32'd7, 4'b0100, "R1");
    send(32'hFFFF_FFFF, 32'h1, 4'b0101, "R1");
    send(32'h7FFF_FFFF, 32'h1, 4'b0100, "R3");
    send(32'h8000_0000, 32'h8000_0000, 4'b0100, "R3");
    send(32'h7FFF_FFFF, 32'h1, 4'b0101, "R3");
    send(32'd9, 32'd9, 4'b0110, "R2");
    send(32'd3, 32'd4, 4'b0111, "R2");
    send(32'h8000_0000, 32'h1, 4'b0110, "R3");
    send(32'h8000_0000, 32'h1, 4'b0111, "R3");
    send(32'd3, 32'd4, 4'b1010, "R5");
    send(32'hFFFF_FFFE, 32'd4, 4'b1010, "R5");
    send(32'd4, 32'hFFFF_FFFE, 4'b1010, "R5");
    send(32'hFFFF_FFF0, 32'hFFFF_FFFE, 4'b1010, "R5");
    send(32'd6, 32'd6, 4'b1010, "R5");
    send(32'h8000_0000, 32'h1, 4'b1010, "R5");
    send(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b1010, "R5");
    send(32'd4, 32'hFFFF_FFFE, 4'b1011, "R6");
    send(32'hFFFF_FFFE, 32'd4, 4'b1011, "R6");
    send(32'd6, 32'd6, 4'b1011, "R6");
    send(32'd1, 32'd2, 4'b1000, "R7");
    send(32'd1, 32'd2, 4'b1001, "R8");
    ra = 32'hACE1_2345; rb = 32'h1357_9BDF;
    for (int i = 0; i < 256; i++) begin
      ra = {ra[30:0], ra[31] ^ ra[21] ^ ra[1] ^ ra[0]} + 32'h9E37;
      rb = rb * 32'd1103515245 + 32'd12345;
      send(ra, (i % 5 == 0) ? ra : rb, 4'(i % 16), (i % 16) >= 8 ? "R8" : "R1");
    end
    @(posedge clk); @(posedge clk);
    done = 1;
  end
endmodule